// File: doc/BRIEF.md
# Normalized-Offset Min-Sum Check Node

This block is the check node processor of a soft-decision LDPC decoder. Each accepted beat carries one signed soft message per edge of a check node, either six or seven edges. For every edge the block returns an extrinsic message. The magnitude of that message is the smallest magnitude found among the other edges. The sign is the product of the other edges' signs. The magnitude is then corrected by a normalization factor and an offset. The message memories, the bit node update and the iteration schedule belong to the surrounding decoder.

The block finds the smallest magnitude, the second smallest magnitude and the position of the smallest one in a single pass. Each edge then takes the second value when it holds the first. Only the two candidate magnitudes pass through the correction arithmetic, and the result is clamped to the six-bit magnitude range. The correction factors can be retuned between decoding iterations. Software writes a staging copy through a small configuration port, and an iteration-start strobe moves the staged values into the copy the datapath uses. There is one register stage after the minimum search and one at the output. The reset input is expected to be already synchronized to the clock.

Top module: `cn_nms_node`

## Requirements
- R1: After reset, out_valid is 0, every output lane is 0, and the factors in use are offset 0 and normalization 4 (1.0), so an unconfigured node computes plain min-sum.
- R2: out_valid pulses exactly two clock edges after the edge that sampled in_valid. Between pulses, out_msgs keeps its last value.
- R3: For edge e, the magnitude is the minimum of |x_j| over all active edges j other than e. An input of -64 counts as magnitude 63.
- R4: Messages are 7-bit two's complement and lane e sits at bits [7e+6:7e]. The output sign is the XOR of the sign bits (bit 6) of the other active edges. The output is never -64, and a zero magnitude gives 0.
- R5: The corrected magnitude is floor(beta*m/4) - alpha. It is clamped below at 0 and above at 63. Beta is 3-bit unsigned with two fractional bits, and alpha is 4-bit unsigned.
- R6: When deg_full is 0 the node has six edges. Lane 6 of the input is then ignored, and lane 6 of the output is 0.
- R7: A cfg_wr with cfg_sel=0 writes cfg_data into the staged alpha. A cfg_wr with cfg_sel=1 writes cfg_data[2:0] into the staged beta. Staged values do not affect outputs until iter_start.
- R8: iter_start copies the staged factors into the active ones. A message accepted in the same cycle as iter_start already uses the new factors.
- R9: When cfg_wr and iter_start coincide, the apply copies the staged contents from before the write. The write stays staged for the next iter_start.
- R10: When several edges share the minimum magnitude, every edge, including those holding it, gets that minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts the beat on in_msgs |
| deg_full | input | 1 | 1: seven edges, 0: six edges |
| in_msgs | input | 49 | Bit-to-check messages, lane e at [7e+6:7e] |
| cfg_wr | input | 1 | Writes a staged correction factor |
| cfg_sel | input | 1 | 0: alpha, 1: beta |
| cfg_data | input | 4 | Factor value (beta uses bits [2:0]) |
| iter_start | input | 1 | Applies staged factors |
| out_valid | output | 1 | Output beat valid |
| out_msgs | output | 49 | Check-to-bit messages, same lane layout |

## Verification
Retuning the factors can fall in the same cycle as message intake, and a configuration write can fall in the same cycle as the apply strobe. The bench raises iter_start together with in_valid and expects the outputs to follow the newly staged factors. In a separate step it raises cfg_wr together with iter_start and expects the apply to carry the older staged offset. A later iter_start, with no new write in between, must then bring in the written value, and both are judged lane by lane against a reference model.

// File: rtl/cn_nms_pkg.sv
package cn_nms_pkg;

  typedef enum logic {
    FACT_ALPHA = 1'b0,
    FACT_BETA  = 1'b1
  } fact_sel_e;

  localparam int unsigned BETA_FRAC = 2;

endpackage

// File: rtl/cn_magsign.sv
module cn_magsign #(
  parameter int unsigned DEG_MAX = 7,
  parameter int unsigned DEG_MIN = 6,
  parameter int unsigned MSG_W   = 7,
  localparam int unsigned MAG_W  = MSG_W - 1
) (
  input  logic [DEG_MAX*MSG_W-1:0] msgs_i,
  input  logic                     deg_full_i,
  output logic [DEG_MAX*MAG_W-1:0] mags_o,
  output logic [DEG_MAX-1:0]       sgns_o
);

  for (genvar e = 0; e < DEG_MAX; e++) begin : g_edge
    logic [MSG_W-1:0] raw;
    logic [MSG_W-1:0] absval;
    logic             live;

    assign raw    = msgs_i[e*MSG_W +: MSG_W];
    assign absval = raw[MSG_W-1] ? (~raw + 1'b1) : raw;

    if (e < DEG_MIN) begin : g_fixed
      assign live = 1'b1;
    end else begin : g_optional
      assign live = deg_full_i;
    end

    // inactive edges look like the largest magnitude with a positive sign
    always_comb begin
      if (!live || absval[MSG_W-1]) begin
        mags_o[e*MAG_W +: MAG_W] = {MAG_W{1'b1}};
      end else begin
        mags_o[e*MAG_W +: MAG_W] = absval[MAG_W-1:0];
      end
      sgns_o[e] = live & raw[MSG_W-1];
    end
  end

endmodule

// File: rtl/cn_twomin.sv
module cn_twomin #(
  parameter int unsigned DEG   = 7,
  parameter int unsigned MAG_W = 6,
  localparam int unsigned IDX_W = (DEG > 1) ? $clog2(DEG) : 1
) (
  input  logic [DEG*MAG_W-1:0] mags_i,
  output logic [MAG_W-1:0]     min1_o,
  output logic [MAG_W-1:0]     min2_o,
  output logic [IDX_W-1:0]     idx_o
);

  always_comb begin
    logic [MAG_W-1:0] cur;
    min1_o = {MAG_W{1'b1}};
    min2_o = {MAG_W{1'b1}};
    idx_o  = '0;
    for (int e = 0; e < DEG; e++) begin
      cur = mags_i[e*MAG_W +: MAG_W];
      if (cur < min1_o) begin
        min2_o = min1_o;
        min1_o = cur;
        idx_o  = IDX_W'(e);
      end else if (cur < min2_o) begin
        min2_o = cur;
      end
    end
  end

endmodule

// File: rtl/cn_correct.sv
module cn_correct
  import cn_nms_pkg::*;
#(
  parameter int unsigned MAG_W   = 6,
  parameter int unsigned ALPHA_W = 4,
  parameter int unsigned BETA_W  = 3
) (
  input  logic [MAG_W-1:0]   mag_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  input  logic [BETA_W-1:0]  beta_i,
  output logic [MAG_W-1:0]   mag_o
);

  localparam int unsigned PROD_W = MAG_W + BETA_W;
  localparam int unsigned SCL_W  = PROD_W - BETA_FRAC;
  localparam int unsigned DIF_W  = ((SCL_W > ALPHA_W) ? SCL_W : ALPHA_W) + 1;

  logic [PROD_W-1:0] prod;
  logic [SCL_W-1:0]  scaled;
  logic [DIF_W-1:0]  diff;

  always_comb begin
    prod   = PROD_W'(mag_i) * PROD_W'(beta_i);
    scaled = SCL_W'(prod >> BETA_FRAC);
    diff   = DIF_W'(scaled) - DIF_W'(alpha_i);
    if (diff[DIF_W-1]) begin
      mag_o = '0;
    end else if (diff[DIF_W-2:0] > (DIF_W-1)'({MAG_W{1'b1}})) begin
      mag_o = {MAG_W{1'b1}};
    end else begin
      mag_o = diff[MAG_W-1:0];
    end
  end

endmodule

// File: rtl/cn_nms_node.sv
module cn_nms_node
  import cn_nms_pkg::*;
#(
  parameter int unsigned DEG_MAX   = 7,
  parameter int unsigned DEG_MIN   = 6,
  parameter int unsigned MSG_W     = 7,
  parameter int unsigned ALPHA_W   = 4,
  parameter int unsigned BETA_W    = 3,
  parameter int unsigned ALPHA_RST = 0,
  parameter int unsigned BETA_RST  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     deg_full,
  input  logic [DEG_MAX*MSG_W-1:0] in_msgs,
  input  logic                     cfg_wr,
  input  logic                     cfg_sel,
  input  logic [ALPHA_W-1:0]       cfg_data,
  input  logic                     iter_start,
  output logic                     out_valid,
  output logic [DEG_MAX*MSG_W-1:0] out_msgs
);

  localparam int unsigned MAG_W = MSG_W - 1;
  localparam int unsigned IDX_W = (DEG_MAX > 1) ? $clog2(DEG_MAX) : 1;

  // ---------------- correction factor staging ----------------
  logic [ALPHA_W-1:0] stg_alpha, stg_alpha_nx, act_alpha, act_alpha_nx;
  logic [BETA_W-1:0]  stg_beta,  stg_beta_nx,  act_beta,  act_beta_nx;

  always_comb begin
    stg_alpha_nx = stg_alpha;
    stg_beta_nx  = stg_beta;
    if (cfg_wr) begin
      if (fact_sel_e'(cfg_sel) == FACT_BETA) begin
        stg_beta_nx = cfg_data[BETA_W-1:0];
      end else begin
        stg_alpha_nx = cfg_data;
      end
    end
    act_alpha_nx = iter_start ? stg_alpha : act_alpha;
    act_beta_nx  = iter_start ? stg_beta  : act_beta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_alpha <= ALPHA_W'(ALPHA_RST);
      stg_beta  <= BETA_W'(BETA_RST);
      act_alpha <= ALPHA_W'(ALPHA_RST);
      act_beta  <= BETA_W'(BETA_RST);
    end else begin
      stg_alpha <= stg_alpha_nx;
      stg_beta  <= stg_beta_nx;
      act_alpha <= act_alpha_nx;
      act_beta  <= act_beta_nx;
    end
  end

  // ---------------- stage 1: sign/magnitude and two-minimum search ----------------
  logic [DEG_MAX*MAG_W-1:0] mags;
  logic [DEG_MAX-1:0]       sgns;
  logic [MAG_W-1:0]         min1, min2;
  logic [IDX_W-1:0]         idx;

  cn_magsign #(
    .DEG_MAX(DEG_MAX),
    .DEG_MIN(DEG_MIN),
    .MSG_W  (MSG_W)
  ) u_magsign (
    .msgs_i    (in_msgs),
    .deg_full_i(deg_full),
    .mags_o    (mags),
    .sgns_o    (sgns)
  );

  cn_twomin #(
    .DEG  (DEG_MAX),
    .MAG_W(MAG_W)
  ) u_twomin (
    .mags_i(mags),
    .min1_o(min1),
    .min2_o(min2),
    .idx_o (idx)
  );

  logic               s1_valid;
  logic [MAG_W-1:0]   s1_min1, s1_min2;
  logic [IDX_W-1:0]   s1_idx;
  logic [DEG_MAX-1:0] s1_sgns;
  logic               s1_par;
  logic               s1_full;
  logic [ALPHA_W-1:0] s1_alpha;
  logic [BETA_W-1:0]  s1_beta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_min1  <= '0;
      s1_min2  <= '0;
      s1_idx   <= '0;
      s1_sgns  <= '0;
      s1_par   <= 1'b0;
      s1_full  <= 1'b0;
      s1_alpha <= '0;
      s1_beta  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_min1  <= min1;
        s1_min2  <= min2;
        s1_idx   <= idx;
        s1_sgns  <= sgns;
        s1_par   <= ^sgns;
        s1_full  <= deg_full;
        s1_alpha <= act_alpha_nx;
        s1_beta  <= act_beta_nx;
      end
    end
  end

  // ---------------- stage 2: correction and lane assembly ----------------
  logic [MAG_W-1:0] cor1, cor2;

  cn_correct #(
    .MAG_W  (MAG_W),
    .ALPHA_W(ALPHA_W),
    .BETA_W (BETA_W)
  ) u_cor_first (
    .mag_i  (s1_min1),
    .alpha_i(s1_alpha),
    .beta_i (s1_beta),
    .mag_o  (cor1)
  );

  cn_correct #(
    .MAG_W  (MAG_W),
    .ALPHA_W(ALPHA_W),
    .BETA_W (BETA_W)
  ) u_cor_second (
    .mag_i  (s1_min2),
    .alpha_i(s1_alpha),
    .beta_i (s1_beta),
    .mag_o  (cor2)
  );

  logic [DEG_MAX*MSG_W-1:0] lanes_nx;

  for (genvar e = 0; e < DEG_MAX; e++) begin : g_lane
    logic [MAG_W-1:0] pick;
    logic [MSG_W-1:0] pos;
    logic             neg;
    logic             live;

    if (e < DEG_MIN) begin : g_fixed
      assign live = 1'b1;
    end else begin : g_optional
      assign live = s1_full;
    end

    always_comb begin
      pick = (s1_idx == IDX_W'(e)) ? cor2 : cor1;
      pos  = {1'b0, pick};
      neg  = s1_par ^ s1_sgns[e];
      if (!live) begin
        lanes_nx[e*MSG_W +: MSG_W] = '0;
      end else if (neg) begin
        lanes_nx[e*MSG_W +: MSG_W] = ~pos + 1'b1;
      end else begin
        lanes_nx[e*MSG_W +: MSG_W] = pos;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msgs  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_msgs <= lanes_nx;
      end
    end
  end

endmodule

// File: rtl/cn_nms_node_chk.sv
module cn_nms_node_chk #(
  parameter int unsigned DEG_MAX = 7,
  parameter int unsigned DEG_MIN = 6,
  parameter int unsigned MSG_W   = 7,
  parameter int unsigned ALPHA_W = 4,
  parameter int unsigned BETA_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     deg_full,
  input logic                     iter_start,
  input logic                     out_valid,
  input logic [DEG_MAX*MSG_W-1:0] out_msgs,
  input logic [ALPHA_W-1:0]       stg_alpha,
  input logic [BETA_W-1:0]        stg_beta,
  input logic [ALPHA_W-1:0]       act_alpha,
  input logic [BETA_W-1:0]        act_beta
);

  a_r2_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r2_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_msgs));

  for (genvar e = 0; e < DEG_MAX; e++) begin : g_lane_chk
    a_r4_never_most_negative: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_msgs[e*MSG_W +: MSG_W] != {1'b1, {(MSG_W-1){1'b0}}}));
  end

  for (genvar e = DEG_MIN; e < DEG_MAX; e++) begin : g_short_chk
    a_r6_short_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(deg_full, 2)) |-> (out_msgs[e*MSG_W +: MSG_W] == '0));
  end

  a_r7_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !iter_start |=> ($stable(act_alpha) && $stable(act_beta)));

  a_r8_apply_copies: assert property (@(posedge clk) disable iff (!rst_n)
    iter_start |=> (act_alpha == $past(stg_alpha) && act_beta == $past(stg_beta)));

endmodule

bind cn_nms_node cn_nms_node_chk #(
  .DEG_MAX(DEG_MAX),
  .DEG_MIN(DEG_MIN),
  .MSG_W  (MSG_W),
  .ALPHA_W(ALPHA_W),
  .BETA_W (BETA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .deg_full  (deg_full),
  .iter_start(iter_start),
  .out_valid (out_valid),
  .out_msgs  (out_msgs),
  .stg_alpha (stg_alpha),
  .stg_beta  (stg_beta),
  .act_alpha (act_alpha),
  .act_beta  (act_beta)
);

// File: tb/cn_nms_node_tb_top.sv
module cn_nms_node_tb_top;

  localparam int NL = 7;
  localparam int MW = 7;

  typedef struct packed {
    logic [NL*MW-1:0] m;
    logic             full;
    logic [3:0]       a;
    logic [2:0]       b;
  } vec_t;

  // lane 6 written first, lane 0 last
  localparam vec_t TBL [9] = '{
    '{ {7'd10, -7'sd20, 7'd5, 7'd30, -7'sd7, 7'd12, 7'd63},       1'b1, 4'd0,  3'd4 },
    '{ {7'd1, 7'd8, -7'sd9, 7'd40, -7'sd3, 7'd22, 7'd17},         1'b0, 4'd0,  3'd4 },
    '{ {-7'sd64, 7'd20, -7'sd20, 7'd15, 7'd33, -7'sd2, 7'd9},     1'b1, 4'd1,  3'd3 },
    '{ {7'd5, 7'd5, -7'sd30, 7'd44, -7'sd5, 7'd60, 7'd10},        1'b1, 4'd2,  3'd3 },
    '{ {7'd0, 7'd50, -7'sd40, 7'd33, 7'd20, -7'sd25, 7'd31},      1'b0, 4'd15, 3'd4 },
    '{ {-7'sd60, 7'd62, -7'sd61, 7'd63, -7'sd63, 7'd60, 7'd61},   1'b1, 4'd0,  3'd7 },
    '{ {-7'sd9, -7'sd14, -7'sd3, -7'sd27, -7'sd8, -7'sd50, -7'sd6}, 1'b1, 4'd3, 3'd2 },
    '{ {7'd12, -7'sd18, 7'd25, -7'sd4, 7'd19, 7'd30, -7'sd22},    1'b1, 4'd0,  3'd0 },
    '{ {7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0},                1'b1, 4'd0,  3'd4 }
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             deg_full;
  logic [NL*MW-1:0] in_msgs;
  logic             cfg_wr;
  logic             cfg_sel;
  logic [3:0]       cfg_data;
  logic             iter_start;
  logic             out_valid;
  logic [NL*MW-1:0] out_msgs;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  cn_nms_node dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .deg_full  (deg_full),
    .in_msgs   (in_msgs),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .iter_start(iter_start),
    .out_valid (out_valid),
    .out_msgs  (out_msgs)
  );

  function automatic logic [MW-1:0] ref_lane(logic [NL*MW-1:0] m, logic full,
                                             int e, int a, int b);
    int n = full ? 7 : 6;
    int mn = 63;
    int v;
    logic s = 1'b0;
    if (e >= n) return '0;
    for (int j = 0; j < n; j++) begin
      if (j != e) begin
        int x = $signed(m[j*MW +: MW]);
        int mag = (x < 0) ? -x : x;
        if (mag > 63) mag = 63;
        if (mag < mn) mn = mag;
        s ^= (x < 0);
      end
    end
    v = (b * mn) / 4 - a;
    if (v < 0) v = 0;
    if (v > 63) v = 63;
    return s ? MW'(-v) : MW'(v);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; cfg_wr = 1'b0; iter_start = 1'b0;
  endtask

  task automatic cfg_write(input logic sel, input logic [3:0] d);
    @(negedge clk);
    in_valid = 1'b0; iter_start = 1'b0;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
  endtask

  task automatic apply();
    @(negedge clk);
    in_valid = 1'b0; cfg_wr = 1'b0; iter_start = 1'b1;
  endtask

  // drives one beat, optionally with iter_start in the same cycle
  task automatic send(input logic [NL*MW-1:0] m, input logic full, input logic with_apply);
    @(negedge clk);
    cfg_wr = 1'b0; iter_start = with_apply;
    in_valid = 1'b1; in_msgs = m; deg_full = full;
  endtask

  // after send: idle, then sample just past the second edge
  task automatic expect_out(input logic [NL*MW-1:0] m, input logic full,
                            input int a, input int b, input string tag);
    idle();
    @(posedge clk);
    #1;
    check(out_valid === 1'b1, {tag, " R2 valid"}, int'(out_valid), 1);
    for (int e = 0; e < NL; e++) begin
      logic [MW-1:0] exp = ref_lane(m, full, e, a, b);
      check(out_msgs[e*MW +: MW] === exp, tag,
            $signed(out_msgs[e*MW +: MW]), $signed(exp));
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [NL*MW-1:0] held;
    logic [NL*MW-1:0] pat;
    rst_n = 1'b0; in_valid = 1'b0; deg_full = 1'b1; in_msgs = '0;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_data = '0; iter_start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(out_msgs === '0, "R1 reset lanes", int'(out_msgs[MW-1:0]), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: default factors give plain min-sum
    send(TBL[0].m, 1'b1, 1'b0);
    expect_out(TBL[0].m, 1'b1, 0, 4, "R1 R3 default factors");

    // R2: outputs hold while no beat is accepted
    held = out_msgs;
    idle();
    @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R2 pulse width", int'(out_valid), 0);
    check(out_msgs === held, "R2 hold", int'(out_msgs[MW-1:0]), int'(held[MW-1:0]));

    // table walk: R3 R4 R5 R6 R10
    for (int i = 0; i < 9; i++) begin
      cfg_write(1'b0, TBL[i].a);
      cfg_write(1'b1, {1'b0, TBL[i].b});
      apply();
      send(TBL[i].m, TBL[i].full, 1'b0);
      expect_out(TBL[i].m, TBL[i].full, TBL[i].a, TBL[i].b,
                 TBL[i].full ? "R3 R4 R5 R10 table" : "R6 table");
    end

    // R6: small lane 6 input must not leak in when six edges are used
    pat = {-7'sd1, 7'd20, -7'sd30, 7'd25, 7'd40, -7'sd35, 7'd22};
    cfg_write(1'b0, 4'd0);
    cfg_write(1'b1, 4'd4);
    apply();
    send(pat, 1'b0, 1'b0);
    expect_out(pat, 1'b0, 0, 4, "R6 lane6 ignored");

    // R7: staged writes without apply leave outputs unchanged
    cfg_write(1'b0, 4'd5);
    cfg_write(1'b1, 4'd2);
    send(pat, 1'b1, 1'b0);
    expect_out(pat, 1'b1, 0, 4, "R7 staged not applied");

    // R8: apply in the same cycle as intake uses the staged values
    send(pat, 1'b1, 1'b1);
    expect_out(pat, 1'b1, 5, 2, "R8 apply with intake");

    // R9: write colliding with apply
    cfg_write(1'b1, 4'd4);
    cfg_write(1'b0, 4'd2);
    @(negedge clk);
    in_valid = 1'b0; cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 4'd9; iter_start = 1'b1;
    send(pat, 1'b1, 1'b0);
    expect_out(pat, 1'b1, 2, 4, "R9 apply takes older staged");
    apply();
    send(pat, 1'b1, 1'b0);
    expect_out(pat, 1'b1, 9, 4, "R9 write kept for next apply");

    // R2: back-to-back beats
    send(TBL[3].m, 1'b1, 1'b0);
    send(TBL[6].m, 1'b1, 1'b0);
    idle();
    #1;
    check(out_valid === 1'b1, "R2 first of pair", int'(out_valid), 1);
    check(out_msgs[MW-1:0] === ref_lane(TBL[3].m, 1'b1, 0, 9, 4), "R2 first lane0",
          int'(out_msgs[MW-1:0]), int'(ref_lane(TBL[3].m, 1'b1, 0, 9, 4)));
    @(posedge clk);
    #1;
    check(out_valid === 1'b1, "R2 second of pair", int'(out_valid), 1);
    check(out_msgs[MW-1:0] === ref_lane(TBL[6].m, 1'b1, 0, 9, 4), "R2 second lane0",
          int'(out_msgs[MW-1:0]), int'(ref_lane(TBL[6].m, 1'b1, 0, 9, 4)));

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule